// File: doc/BRIEF.md
# Fail-Safe Four-State Sequencer with Zero-Reset State Register

This block is a small Moore sequencer whose four-bit state register lives on flip-flops that may only clear to zero. Its logical idle code is a mix of ones and zeros, so the flip-flops hold a transformed code. A fixed inversion mask is applied wherever the register is read, and applied again where the next value is written back. The sequencer starts in its idle state and steps once to a start state. It then alternates between two run states for as long as the clock runs. A single registered output is low while idle and high in every other legal state.

All sixteen values the register can hold have a defined successor and a defined output. This covers values left by a power-up or an upset with no reset. Any value that does not map to a legal code gives a low output and returns to idle on the next edge. The all-ones value maps to the legal start state, so it simply joins the normal sequence. Reset asserts asynchronously from an active-low pin and is released through a short synchronizer. A four-bit observation port shows the logical state code.

Top module: `fsm_seq_top`

## Requirements
- R1: While rst_n is low, obs_state reads 0101 (idle) and y_out reads 0; this takes effect without waiting for a clock edge.
- R2: After rst_n rises, the state stays idle through the first SYNC_STAGES rising clock edges (default 2) and leaves idle on the next one.
- R3: Out of reset, the logical sequence is idle 0101, then start 1010, then run-A 0110, then run-B 1001, then run-A, alternating run-A and run-B indefinitely.
- R4: y_out after a rising edge equals the output decoded from the state held before that edge: 0 for idle and for any illegal code, 1 for start, run-A and run-B.
- R5: obs_state always equals the physical register XOR 0101, so the physical codes are idle 0000, run-A 0011, run-B 1100 and start 1111.
- R6: Each of the twelve physical values 0001, 0010, 0100, 0101, 0110, 0111, 1000, 1001, 1010, 1011, 1101 and 1110 moves to idle (obs_state 0101) on the next rising edge and loads y_out with 0.
- R7: A physical all-ones value present without any reset is the start state: it reads as 1010, loads y_out with 1 and moves to run-A on the next edge.
- R8: If rst_n falls in the same cycle that the register holds an illegal value, reset takes priority: obs_state reads 0101 and y_out reads 0 at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| y_out | output | 1 | Registered sequencer output |
| obs_state | output | 4 | Logical state code (physical register XOR 0101) |

## Verification
Two functions can act in the same cycle: illegal-state recovery and reset assertion. The bench loads an illegal register value between clock edges and pulls rst_n low at the same moment. It then checks that the idle code and a low output appear at once, before any edge could run the recovery path. Both functions are also exercised on their own. Random register loads and random reset pulses are mixed into long free-running stretches, and each result is compared with a transition model inside the bench.

// File: rtl/fsm_seq_pkg.sv
package fsm_seq_pkg;
  parameter int STATE_W = 4;
  typedef logic [STATE_W-1:0] code_t;

  // Logical codes; the idle code doubles as the inversion mask so that
  // the physical idle value is all zeros.
  localparam code_t CODE_IDLE  = 4'b0101;
  localparam code_t CODE_RUN_A = 4'b0110;
  localparam code_t CODE_RUN_B = 4'b1001;
  localparam code_t CODE_START = 4'b1010;
  localparam code_t INV_MASK   = CODE_IDLE;
endpackage

// File: rtl/fsm_rst_sync.sv
module fsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fsm_code_map.sv
module fsm_code_map
  import fsm_seq_pkg::*;
(
  input  code_t code_in,
  output code_t code_out
);
  // Per-bit inversion selected by the mask; applying it twice is identity,
  // so the same map converts physical to logical and back.
  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    if (INV_MASK[i]) begin : g_inv
      assign code_out[i] = ~code_in[i];
    end else begin : g_pass
      assign code_out[i] = code_in[i];
    end
  end
endmodule

// File: rtl/fsm_next.sv
module fsm_next
  import fsm_seq_pkg::*;
(
  input  code_t cur_log,
  output code_t nxt_log,
  output logic  out_d
);
  always_comb begin
    unique case (cur_log)
      CODE_IDLE:  begin nxt_log = CODE_START; out_d = 1'b0; end
      CODE_START: begin nxt_log = CODE_RUN_A; out_d = 1'b1; end
      CODE_RUN_A: begin nxt_log = CODE_RUN_B; out_d = 1'b1; end
      CODE_RUN_B: begin nxt_log = CODE_RUN_A; out_d = 1'b1; end
      default:    begin nxt_log = CODE_IDLE;  out_d = 1'b0; end
    endcase
  end
endmodule

// File: rtl/fsm_seq_top.sv
module fsm_seq_top
  import fsm_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               y_out,
  output logic [STATE_W-1:0] obs_state
);
  logic  rst_sync_n;
  code_t state_q;
  code_t state_d;
  code_t cur_log;
  code_t nxt_log;
  logic  out_d;
  logic  y_q;

  fsm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsm_code_map u_rd_map (
    .code_in  (state_q),
    .code_out (cur_log)
  );

  fsm_next u_next (
    .cur_log (cur_log),
    .nxt_log (nxt_log),
    .out_d   (out_d)
  );

  fsm_code_map u_wr_map (
    .code_in  (nxt_log),
    .code_out (state_d)
  );

  // State register: clears to all zeros only.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= '0;
    else             state_q <= state_d;
  end

  // Output register.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) y_q <= 1'b0;
    else             y_q <= out_d;
  end

  assign y_out     = y_q;
  assign obs_state = cur_log;
endmodule

// File: rtl/fsm_seq_chk.sv
module fsm_seq_chk
  import fsm_seq_pkg::*;
(
  input logic  clk,
  input logic  rst_sync_n,
  input code_t obs_state,
  input code_t nxt_log,
  input logic  y_out
);
  logic obs_active;
  logic obs_legal;
  assign obs_active = (obs_state == CODE_START) || (obs_state == CODE_RUN_A) ||
                      (obs_state == CODE_RUN_B);
  assign obs_legal  = obs_active || (obs_state == CODE_IDLE);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_sync_n |-> (obs_state == CODE_IDLE) && !y_out); // R1

  AST_IDLE_TO_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (obs_state == CODE_IDLE) |-> (nxt_log == CODE_START)); // R3

  AST_START_TO_RUN_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (obs_state == CODE_START) |-> (nxt_log == CODE_RUN_A)); // R7

  AST_RUN_A_TO_RUN_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (obs_state == CODE_RUN_A) |-> (nxt_log == CODE_RUN_B)); // R3

  AST_RUN_B_TO_RUN_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (obs_state == CODE_RUN_B) |-> (nxt_log == CODE_RUN_A)); // R3

  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !obs_legal |-> (nxt_log == CODE_IDLE)); // R6

  AST_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    obs_active |=> y_out); // R4

  AST_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !obs_active |=> !y_out); // R4
endmodule

bind fsm_seq_top fsm_seq_chk chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .obs_state  (obs_state),
  .nxt_log    (nxt_log),
  .y_out      (y_out)
);

// File: tb/fsm_seq_top_tb_top.sv
module fsm_seq_top_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int SYNC_STAGES = 2;
  localparam logic [3:0] L_IDLE  = 4'b0101;
  localparam logic [3:0] L_RUN_A = 4'b0110;
  localparam logic [3:0] L_RUN_B = 4'b1001;
  localparam logic [3:0] L_START = 4'b1010;
  localparam logic [3:0] MASK    = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       y_out;
  logic [3:0] obs_state;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] exp_state;
  logic       exp_y;

  fsm_seq_top #(.SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .y_out     (y_out),
    .obs_state (obs_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic is_legal(logic [3:0] s);
    return (s == L_IDLE) || (s == L_START) || (s == L_RUN_A) || (s == L_RUN_B);
  endfunction

  function automatic logic model_out(logic [3:0] s);
    return (s == L_START) || (s == L_RUN_A) || (s == L_RUN_B);
  endfunction

  function automatic logic [3:0] model_next(logic [3:0] s);
    case (s)
      L_IDLE:  return L_START;
      L_START: return L_RUN_A;
      L_RUN_A: return L_RUN_B;
      L_RUN_B: return L_RUN_A;
      default: return L_IDLE;
    endcase
  endfunction

  function automatic string tag_for(logic [3:0] s);
    if (s == L_START) return "R7";
    if (!is_legal(s)) return "R6";
    return "R3";
  endfunction

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // One clock; checks at the following falling edge.
  task automatic step();
    string t;
    t = tag_for(exp_state);
    @(posedge clk);
    exp_y     = model_out(exp_state);
    exp_state = model_next(exp_state);
    @(negedge clk);
    chk(t, obs_state, exp_state);
    chk("R4", {3'b0, y_out}, {3'b0, exp_y});
  endtask

  // Called at a falling edge: loads a physical value between edges.
  task automatic load_phys(logic [3:0] v);
    force dut_i.state_q = v;
    release dut_i.state_q;
    exp_state = v ^ MASK;
    #1;
    chk("R5", obs_state, exp_state);
  endtask

  // rst_n already low: check, then release and count the sync edges.
  task automatic finish_reset();
    #1;
    chk("R1", obs_state, L_IDLE);
    chk("R1", {3'b0, y_out}, 4'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC_STAGES; i++) begin
      @(negedge clk);
      chk("R2", obs_state, L_IDLE);
    end
    exp_state = L_IDLE;
    exp_y     = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    int r;
    void'($urandom(32'd20571));
    @(negedge clk);
    finish_reset();
    chk("R3", obs_state, L_START);
    repeat (6) step();

    // Every physical value, each followed by recovery steps.
    for (int k = 0; k < 16; k++) begin
      load_phys(k[3:0]);
      if (k == 15) chk("R7", obs_state, L_START);
      step();
      step();
    end

    // Reset and illegal value in the same cycle.
    load_phys(4'b0110);
    rst_n = 1'b0;
    #1;
    chk("R8", obs_state, L_IDLE);
    chk("R8", {3'b0, y_out}, 4'b0);
    finish_reset();

    // Random mix.
    for (int it = 0; it < 400; it++) begin
      r = $urandom % 10;
      if (r == 0) begin
        load_phys(4'($urandom));
        step();
      end else if (r == 1) begin
        do v = 4'($urandom); while (is_legal(v ^ MASK));
        load_phys(v);
        rst_n = 1'b0;
        #1;
        chk("R8", obs_state, L_IDLE);
        finish_reset();
      end else begin
        step();
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule